// File: doc/BRIEF.md
# Lockstep Four-Lane Stream Joiner

The joiner takes four valid/ready streams that each carry one quarter of a wide key word and delivers the complete word to a single write port of a batch buffer. Every lane first runs through its own chain of register stages, so the four sources can be placed far apart and can each stall on their own. At the tail of the chains the four lanes are released only as one group. A beat leaves its chain only in a cycle where all four chain outputs hold valid data and the downstream side is ready.

This atomic release is the whole point of the block. If a lane's tail ready depended only on its own state, a momentary stall on one source would let the other three drop their current beats into a write that never happens. The lanes would then stay one or more words apart for good. With the gated ready, a late lane only delays the group. The register stages in front absorb what the early lanes keep sending until their capacity is full, and then push back on their own sources.

Top module: `lockstep_joiner`

## Requirements
- R1: Each of the four lanes is buffered by its own chain of SLICE_DEPTH stages of two entries each. While nothing drains, a lane whose source stays valid accepts exactly 2*SLICE_DEPTH beats and then holds `laneReady` low.
- R2: `wrEn` is high only in a cycle where all four chains present a valid beat. As long as any one lane has delivered nothing, no write occurs.
- R3: No beat is lost and no lane shifts relative to the others. The n-th write carries the n-th accepted beat of every lane, in order.
- R4: `wrEn` is never high while `dsReady` is low. While `dsReady` stays low, buffered beats are kept, and once the chains are full every `laneReady` is low.
- R5: `wrData` is the concatenation of the lane payloads. Lane i occupies bits [i*DATA_W +: DATA_W], with lane 0 in the least significant position.
- R6: With all sources continuously valid and `dsReady` held high, the block writes one word per cycle, with no bubbles between writes.
- R7: A synchronous active-high `rst` empties every stage. In the cycle after reset, `wrEn` is low and all four `laneReady` are high, and beats accepted before the reset never reach `wrData`.
- R8: A lane that holds no beat anywhere in its chain has `laneReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| laneValid | input | 4 | Per-lane source valid, bit i for lane i |
| laneData | input | 4*DATA_W | Per-lane payload, lane i at [i*DATA_W +: DATA_W] |
| laneReady | output | 4 | Per-lane ready back to the source |
| dsReady | input | 1 | Buffer write port can take a word |
| wrEn | output | 1 | Combined write strobe to the buffer |
| wrData | output | 4*DATA_W | Concatenated word, lane 0 least significant |

## Verification
A directed case keeps three lanes valid while the fourth stays silent. It separates an atomic join from one that lets the early lanes advance: any write, or any count other than the stage capacity, reveals the fault. Continuous all-valid traffic tells a full-rate stage apart from one that inserts bubbles. A long downstream stall shows whether the write path ignores `dsReady`. Random per-lane valid stalls mixed with random downstream readiness check that every written word carries the same sequence number in all four fields. A reset in the middle of traffic, followed by fresh numbering, exposes stages that keep stale beats.

// File: rtl/joiner_pkg.sv
package joiner_pkg;
  localparam int LANE_COUNT = 4;

  // Strobes from the join control to the datapath.
  typedef struct packed {
    logic [LANE_COUNT-1:0] pop;  // release tail beat of each lane
    logic                  wrEn; // complete word goes to the buffer
  } joinStrobes_t;
endpackage

// File: rtl/joiner_skid_stage.sv
module joiner_skid_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);
  typedef enum logic [1:0] {EMPTY = 2'd0, ONE = 2'd1, TWO = 2'd2} fill_t;

  fill_t             fillQ;
  logic [DATA_W-1:0] headQ;
  logic [DATA_W-1:0] spareQ;
  logic              push;
  logic              pop;

  // Both handshake outputs come from registers only.
  assign inReady  = (fillQ != TWO);
  assign outValid = (fillQ != EMPTY);
  assign outData  = headQ;
  assign push     = inValid && inReady;
  assign pop      = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillQ <= EMPTY;
    end else begin
      unique case (fillQ)
        EMPTY:   if (push) fillQ <= ONE;
        ONE:     if (push && !pop) fillQ <= TWO;
                 else if (!push && pop) fillQ <= EMPTY;
        TWO:     if (pop) fillQ <= ONE;
        default: fillQ <= EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (fillQ)
      EMPTY:   if (push) headQ <= inData;
      ONE: begin
        if (push && pop) headQ <= inData;
        else if (push) spareQ <= inData;
      end
      TWO:     if (pop) headQ <= spareQ;
      default: headQ <= headQ;
    endcase
  end
endmodule

// File: rtl/joiner_datapath.sv
module joiner_datapath
  import joiner_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SLICE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANE_COUNT-1:0]        laneValid,
  input  logic [LANE_COUNT*DATA_W-1:0] laneData,
  output logic [LANE_COUNT-1:0]        laneReady,
  output logic [LANE_COUNT-1:0]        tailValid,
  input  joinStrobes_t                 strobes,
  output logic                         wrEn,
  output logic [LANE_COUNT*DATA_W-1:0] wrData
);
  localparam int NODES = SLICE_DEPTH + 1;

  for (genvar lane = 0; lane < LANE_COUNT; lane++) begin : g_lane
    logic [NODES-1:0]             vld;
    logic [NODES-1:0]             rdy;
    logic [NODES-1:0][DATA_W-1:0] dat;

    assign vld[0]          = laneValid[lane];
    assign dat[0]          = laneData[lane*DATA_W +: DATA_W];
    assign laneReady[lane] = rdy[0];

    for (genvar s = 0; s < SLICE_DEPTH; s++) begin : g_stage
      joiner_skid_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .inValid  (vld[s]),
        .inData   (dat[s]),
        .inReady  (rdy[s]),
        .outValid (vld[s+1]),
        .outData  (dat[s+1]),
        .outReady (rdy[s+1])
      );
    end

    // The tail only advances when the control releases the whole group.
    assign rdy[SLICE_DEPTH]              = strobes.pop[lane];
    assign tailValid[lane]               = vld[SLICE_DEPTH];
    assign wrData[lane*DATA_W +: DATA_W] = dat[SLICE_DEPTH];
  end

  assign wrEn = strobes.wrEn;
endmodule

// File: rtl/joiner_control.sv
module joiner_control
  import joiner_pkg::*;
(
  input  logic [LANE_COUNT-1:0] tailValid,
  input  logic                  dsReady,
  output joinStrobes_t          strobes
);
  logic groupValid;
  logic fire;

  assign groupValid = &tailValid;
  assign fire       = groupValid && dsReady;

  always_comb begin
    strobes      = '0;
    strobes.wrEn = fire;
    // Every lane gets the same gated ready: no lane may pop alone.
    strobes.pop  = {LANE_COUNT{fire}};
  end
endmodule

// File: rtl/lockstep_joiner.sv
module lockstep_joiner
  import joiner_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SLICE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANE_COUNT-1:0]        laneValid,
  input  logic [LANE_COUNT*DATA_W-1:0] laneData,
  output logic [LANE_COUNT-1:0]        laneReady,
  input  logic                         dsReady,
  output logic                         wrEn,
  output logic [LANE_COUNT*DATA_W-1:0] wrData
);
  joinStrobes_t          strobes;
  logic [LANE_COUNT-1:0] tailValid;

  joiner_control u_ctrl (
    .tailValid (tailValid),
    .dsReady   (dsReady),
    .strobes   (strobes)
  );

  joiner_datapath #(.DATA_W(DATA_W), .SLICE_DEPTH(SLICE_DEPTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .laneValid (laneValid),
    .laneData  (laneData),
    .laneReady (laneReady),
    .tailValid (tailValid),
    .strobes   (strobes),
    .wrEn      (wrEn),
    .wrData    (wrData)
  );
endmodule

// File: rtl/lockstep_joiner_chk.sv
module lockstep_joiner_chk
  import joiner_pkg::*;
#(
  parameter int SLICE_DEPTH = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANE_COUNT-1:0] laneValid,
  input logic [LANE_COUNT-1:0] laneReady,
  input logic                  dsReady,
  input logic                  wrEn
);
  localparam int CAP   = 2 * SLICE_DEPTH;
  localparam int OCC_W = $clog2(CAP + 1) + 1;

  p_write_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> dsReady);

  p_reset_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wrEn && laneReady == {LANE_COUNT{1'b1}}));

  for (genvar lane = 0; lane < LANE_COUNT; lane++) begin : g_occ
    // Beats held by this lane, counted from port handshakes only.
    logic [OCC_W-1:0] occ;

    always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else occ <= occ + OCC_W'(laneValid[lane] && laneReady[lane]) - OCC_W'(wrEn);
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
      occ <= OCC_W'(CAP));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
      wrEn |-> (occ != '0));

    p_empty_accepts_r8: assert property (@(posedge clk) disable iff (rst)
      (occ == '0) |-> laneReady[lane]);
  end
endmodule

bind lockstep_joiner lockstep_joiner_chk #(.SLICE_DEPTH(SLICE_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .laneValid (laneValid),
  .laneReady (laneReady),
  .dsReady   (dsReady),
  .wrEn      (wrEn)
);

// File: tb/lockstep_joiner_tb.sv
module lockstep_joiner_tb;
  localparam int W     = 16;
  localparam int DEPTH = 4;
  localparam int LANES = 4;
  localparam int CAP   = 2 * DEPTH;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [LANES-1:0]    laneValid = '0;
  logic [LANES*W-1:0]  laneData = '0;
  logic [LANES-1:0]    laneReady;
  logic                dsReady = 1'b0;
  logic                wrEn;
  logic [LANES*W-1:0]  wrData;

  int checks = 0;
  int errors = 0;
  int seqNo [LANES];
  int accCnt [LANES];
  int outCount = 0;
  int phaseWrites = 0;
  int firstW = -1;
  int lastW = -1;
  int cyc = 0;
  bit finished = 1'b0;
  logic [LANES-1:0] acc;

  lockstep_joiner #(.DATA_W(W), .SLICE_DEPTH(DEPTH)) u_dut (
    .clk (clk), .rst (rst), .laneValid (laneValid), .laneData (laneData),
    .laneReady (laneReady), .dsReady (dsReady), .wrEn (wrEn), .wrData (wrData)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] mkBeat(int lane, int s);
    return {lane[1:0], s[W-3:0]};
  endfunction

  function automatic logic [LANES*W-1:0] expWord(int idx);
    logic [LANES*W-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*W +: W] = mkBeat(l, idx);
    return w;
  endfunction

  function automatic int minSeq();
    int m = seqNo[0];
    for (int l = 1; l < LANES; l++) if (seqNo[l] < m) m = seqNo[l];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearPhase();
    phaseWrites = 0; firstW = -1; lastW = -1;
    for (int l = 0; l < LANES; l++) accCnt[l] = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic tick(input logic [LANES-1:0] offer, input logic ds);
    for (int l = 0; l < LANES; l++) begin
      if (!laneValid[l]) laneValid[l] = offer[l];
      laneData[l*W +: W] = mkBeat(l, seqNo[l]);
    end
    dsReady = ds;
    #4;
    acc = laneValid & laneReady;
    if (wrEn) begin
      // R3: same sequence number in every field, in order.
      chk(wrData == expWord(outCount), "R3", wrData, expWord(outCount));
      // R5: field of lane i sits at [i*W +: W].
      for (int l = 0; l < LANES; l++)
        chk(wrData[l*W+W-1 -: 2] == 2'(l), "R5", 64'(wrData[l*W+W-1 -: 2]), 64'(l));
      outCount++; phaseWrites++;
      if (firstW < 0) firstW = cyc;
      lastW = cyc;
    end
    @(negedge clk);
    cyc++;
    for (int l = 0; l < LANES; l++)
      if (acc[l]) begin seqNo[l]++; accCnt[l]++; laneValid[l] = 1'b0; end
  endtask

  task automatic drain();
    repeat (4 * DEPTH + 12) tick('0, 1'b1);
    chk(outCount == minSeq(), "R3", 64'(outCount), 64'(minSeq()));
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; laneValid = '0; dsReady = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int l = 0; l < LANES; l++) seqNo[l] = 0;
    outCount = 0;
    #4;
    chk(wrEn == 1'b0, "R7", 64'(wrEn), 64'd0);
    chk(laneReady == 4'hF, "R7", 64'(laneReady), 64'hF);
    @(negedge clk);
  endtask

  initial begin
    int pr [LANES];
    int target;
    void'($urandom(32'd4242));
    doReset();

    // R1, R2: lane 3 silent, the others valid.
    clearPhase();
    repeat (24) tick(4'b0111, 1'b1);
    for (int l = 0; l < 3; l++) chk(accCnt[l] == CAP, "R1", 64'(accCnt[l]), 64'(CAP));
    chk(phaseWrites == 0, "R2", 64'(phaseWrites), 64'd0);
    #4 chk(laneReady == 4'b1000, "R1", 64'(laneReady), 64'b1000);
    @(negedge clk);
    repeat (40) tick(4'b1111, 1'b1);
    drain();

    // R6: continuous traffic gives back-to-back writes.
    clearPhase();
    target = minSeq() + 40;
    while (minSeq() < target) begin
      logic [LANES-1:0] o;
      for (int l = 0; l < LANES; l++) o[l] = (seqNo[l] < target);
      tick(o, 1'b1);
    end
    drain();
    chk(phaseWrites == 40, "R6", 64'(phaseWrites), 64'd40);
    chk(lastW - firstW + 1 == 40, "R6", 64'(lastW - firstW + 1), 64'd40);

    // R4: downstream stall.
    clearPhase();
    repeat (30) tick(4'b1111, 1'b0);
    chk(phaseWrites == 0, "R4", 64'(phaseWrites), 64'd0);
    #4 chk(laneReady == 4'b0000, "R4", 64'(laneReady), 64'd0);
    @(negedge clk);
    repeat (10) tick(4'b1111, 1'b1);
    drain();

    // R3: random per-lane stalls and random downstream ready.
    for (int blk = 0; blk < 6; blk++) begin
      for (int l = 0; l < LANES; l++) pr[l] = 20 + int'($urandom_range(0, 79));
      repeat (500) begin
        logic [LANES-1:0] o;
        for (int l = 0; l < LANES; l++) o[l] = (int'($urandom_range(0, 99)) < pr[l]);
        tick(o, $urandom_range(0, 99) < 75);
      end
    end
    drain();

    // R7: reset in the middle of traffic.
    repeat (5) tick(4'b0011, 1'b1);
    doReset();
    repeat (30) tick(4'b1111, 1'b1);
    drain();
    chk(outCount == 30, "R7", 64'(outCount), 64'd30);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule